// File: doc/BRIEF.md
# Transition-Mode PFC Gate Timing Controller

This block decides when the switch of a boost power-factor stage turns on and when it turns off. It runs from one fixed system clock. All analog work is done outside the block. Its inputs are already-digitised comparator flags:

- zero current in the inductor, seen on the auxiliary winding;
- current over the limit;
- the PWM ramp crossing the error level;
- output over-voltage;
- burst stop and burst start;
- line range.

It also has an enable input and a fault input. Its single output is a registered gate-drive request.

An on-period begins when the inductor current reaches zero after turn-off. If no zero-current edge arrives for a long time, a restart timer begins the on-period instead. An on-period ends at the earliest of three events:

- the ramp crossing;
- the current limit, once a short blanking window after turn-on has passed;
- a maximum on-time, which is longer at low line than at high line.

A minimum off-time and a minimum turn-on-to-turn-on period cap the switching frequency. A persistent over-voltage and the burst-mode hold both stop switching.

Every duration is a parameter given in clock cycles. The defaults assume a 50 MHz clock, so one cycle is 20 ns. Each comparator flag passes through a two-flop synchroniser. The enable and fault inputs act directly.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, gate_o is 0. It stays 0 as long as ramp_trip_i is held at 1.
- R2: With high_line_i = 0 and no other ending event, an on-period lasts exactly TON_LO_CYC cycles (default 1250, 25 us).
- R3: With high_line_i = 1 and no other ending event, an on-period lasts exactly TON_HI_CYC cycles (default 400, 8 us).
- R4: A change on a comparator input reaches gate_o on the third rising clock edge after it. So if ramp_trip_i rises K cycles after it fell, the gate pulse that its fall started lasts exactly K cycles.
- R5: cs_over_i is ignored for the first BLANK_CYC cycles of an on-period (default 13). If it is held at 1 from before turn-on, the pulse lasts exactly BLANK_CYC cycles. If it rises later, it ends the pulse with the latency of R4.
- R6: After turn-off, gate_o stays 0 for at least TOFF_MIN_CYC cycles (default 50). A zero-current rising edge that arrives at once gives a low time of exactly TOFF_MIN_CYC.
- R7: Turn-on to the next turn-on takes at least TPER_MIN_CYC cycles (default 200). After a 20-cycle pulse with an immediate zero-current edge, the low time is exactly 180.
- R8: If no zero-current rising edge arrives after turn-off, the switch turns on again after exactly RESTART_CYC low cycles (default 2500, 50 us).
- R9: A zero-current rising edge that arrives while the gate is high is discarded. Only an edge after turn-off starts a new on-period.
- R10: Ending an on-period takes priority over starting one. No turn-on, including a restart, is granted in a cycle in which the synchronised ramp flag is 1 or switching is inhibited.
- R11: ovp_i must stay at 1 for OVP_DEB_CYC synchronised cycles (default 2500) before switching stops. A shorter assertion has no effect. Once stopped, switching resumes only after ovp_i returns to 0.
- R12: A 1 on burst_stop_i stops switching. The stop persists after burst_stop_i falls, until burst_start_i is 1. Stop takes precedence when both are 1.
- R13: en_i = 0 or fault_i = 1 forces gate_o to 0 at the next clock edge and clears every timer and latched state. After re-enable, the first restart comes RESTART_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; 0 forces the gate off and clears timers |
| fault_i | input | 1 | Global fault; 1 forces the gate off and clears timers |
| zcd_i | input | 1 | Zero-current flag from the auxiliary winding (rising edge used) |
| cs_over_i | input | 1 | Switch current above limit |
| ramp_trip_i | input | 1 | PWM ramp has crossed the error level |
| ovp_i | input | 1 | Output over-voltage flag (hysteretic comparator) |
| burst_stop_i | input | 1 | Compensation level below the stop threshold |
| burst_start_i | input | 1 | Compensation level above the start threshold |
| high_line_i | input | 1 | 1 = high line range, 0 = low line range |
| gate_o | output | 1 | Registered gate-drive request |

## Verification
Gate pulses are ended in four ways:
- by a ramp flag raised at a chosen cycle;
- by a current-limit flag held from before turn-on;
- by a current-limit flag raised late;
- by neither of these, at both line ranges.

Comparing the measured widths separates the ramp and current-limit paths, the blanking window and the two maximum on-times. Off times are measured after three patterns: a zero-current edge just after turn-off with a long pulse, the same edge with a short pulse, and an edge that arrived during the on-period or never arrived. These separate the minimum off-time, the minimum period and the restart timer. Over-voltage is applied both shorter and longer than its debounce, and burst stop and start are pulsed. Each of these is checked with switching permitted, to show whether it blocks turn-on and when it lets switching go again.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

  typedef enum logic {
    ST_OFF = 1'b0,
    ST_ON  = 1'b1
  } gate_st_e;

  localparam int unsigned SYNC_W     = 7;
  localparam int unsigned IDX_ZCD    = 0;
  localparam int unsigned IDX_CS     = 1;
  localparam int unsigned IDX_RAMP   = 2;
  localparam int unsigned IDX_OVP    = 3;
  localparam int unsigned IDX_BSTOP  = 4;
  localparam int unsigned IDX_BSTART = 5;
  localparam int unsigned IDX_HILINE = 6;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold 0..v-1
  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sr_q[STAGES-1];
  end

endmodule

// File: rtl/pfc_gate_inhibit.sv
module pfc_gate_inhibit #(
  parameter int unsigned OVP_DEB_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ovp_i,
  input  logic bstop_i,
  input  logic bstart_i,
  output logic inhibit_o
);
  import pfc_gate_pkg::*;

  localparam int unsigned OW = cnt_w(OVP_DEB_CYC);
  localparam logic [OW-1:0] OVP_LIM = OW'(OVP_DEB_CYC - 1);

  logic [OW-1:0] ovp_cnt_q;
  logic          ovp_blk_q;
  logic          burst_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovp_cnt_q    <= '0;
      ovp_blk_q    <= 1'b0;
      burst_hold_q <= 1'b0;
    end else if (!run_i) begin
      ovp_cnt_q    <= '0;
      ovp_blk_q    <= 1'b0;
      burst_hold_q <= 1'b0;
    end else begin
      if (!ovp_i) begin
        ovp_cnt_q <= '0;
        ovp_blk_q <= 1'b0;
      end else if (!ovp_blk_q) begin
        if (ovp_cnt_q == OVP_LIM) ovp_blk_q <= 1'b1;
        else                      ovp_cnt_q <= ovp_cnt_q + OW'(1);
      end
      if (bstop_i)       burst_hold_q <= 1'b1;
      else if (bstart_i) burst_hold_q <= 1'b0;
    end
  end

  assign inhibit_o = ovp_blk_q | burst_hold_q;

  // R11
  ovp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ovp_i && ovp_blk_q) |=> ovp_blk_q);

  // R11
  ovp_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovp_blk_q) |-> $past(ovp_i));

  // R12
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && burst_hold_q && !bstart_i) |=> burst_hold_q);

endmodule

// File: rtl/pfc_gate_timer.sv
module pfc_gate_timer #(
  parameter int unsigned TON_LO_CYC   = 1250,
  parameter int unsigned TON_HI_CYC   = 400,
  parameter int unsigned BLANK_CYC    = 13,
  parameter int unsigned TOFF_MIN_CYC = 50,
  parameter int unsigned TPER_MIN_CYC = 200,
  parameter int unsigned RESTART_CYC  = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic zcd_i,
  input  logic cs_i,
  input  logic ramp_i,
  input  logic high_line_i,
  input  logic inhibit_i,
  output logic gate_o
);
  import pfc_gate_pkg::*;

  localparam int unsigned MAXV = max2(max2(max2(TON_LO_CYC, TON_HI_CYC), max2(BLANK_CYC, TOFF_MIN_CYC)),
                                      max2(TPER_MIN_CYC, RESTART_CYC));
  localparam int unsigned CW = cnt_w(MAXV);
  localparam logic [CW-1:0] TON_LO_LIM  = CW'(TON_LO_CYC - 1);
  localparam logic [CW-1:0] TON_HI_LIM  = CW'(TON_HI_CYC - 1);
  localparam logic [CW-1:0] TON_MAX_LIM = CW'(max2(TON_LO_CYC, TON_HI_CYC) - 1);
  localparam logic [CW-1:0] BLANK_LIM   = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] TOFF_LIM    = CW'(TOFF_MIN_CYC - 1);
  localparam logic [CW-1:0] PER_LIM     = CW'(TPER_MIN_CYC - 1);
  localparam logic [CW-1:0] RST_LIM     = CW'(RESTART_CYC - 1);

  gate_st_e      st_q;
  logic [CW-1:0] on_cnt_q, off_cnt_q, per_cnt_q;
  logic          zcd_d_q, zcd_pend_q;

  logic [CW-1:0] ton_lim;
  logic          zcd_rise, end_req, start_trig, start_ok, start_req;
  logic [CW-1:0] per_inc, off_inc;

  assign ton_lim    = high_line_i ? TON_HI_LIM : TON_LO_LIM;
  assign zcd_rise   = zcd_i & ~zcd_d_q;
  assign end_req    = ramp_i | inhibit_i | (cs_i && (on_cnt_q >= BLANK_LIM)) | (on_cnt_q >= ton_lim);
  assign start_trig = zcd_pend_q | zcd_rise | (off_cnt_q >= RST_LIM);
  assign start_ok   = (off_cnt_q >= TOFF_LIM) && (per_cnt_q >= PER_LIM) && !ramp_i && !inhibit_i;
  assign start_req  = start_trig & start_ok;
  assign per_inc    = (per_cnt_q >= PER_LIM) ? per_cnt_q : per_cnt_q + CW'(1);
  assign off_inc    = (off_cnt_q >= RST_LIM) ? off_cnt_q : off_cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OFF;
      on_cnt_q   <= '0;
      off_cnt_q  <= '0;
      per_cnt_q  <= PER_LIM;
      zcd_d_q    <= 1'b0;
      zcd_pend_q <= 1'b0;
    end else begin
      zcd_d_q <= zcd_i;
      if (!run_i) begin
        st_q       <= ST_OFF;
        on_cnt_q   <= '0;
        off_cnt_q  <= '0;
        per_cnt_q  <= PER_LIM;
        zcd_pend_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_OFF: begin
            if (start_req) begin
              st_q       <= ST_ON;
              on_cnt_q   <= '0;
              per_cnt_q  <= '0;
              zcd_pend_q <= 1'b0;
            end else begin
              off_cnt_q <= off_inc;
              per_cnt_q <= per_inc;
              if (zcd_rise) zcd_pend_q <= 1'b1;
            end
          end
          ST_ON: begin
            per_cnt_q <= per_inc;
            if (end_req) begin
              st_q      <= ST_OFF;
              off_cnt_q <= '0;
            end else begin
              on_cnt_q <= on_cnt_q + CW'(1);
            end
          end
          default: st_q <= ST_OFF;
        endcase
      end
    end
  end

  assign gate_o = (st_q == ST_ON);

  // R13
  force_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !gate_o);

  // R2 R3
  on_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (on_cnt_q <= TON_MAX_LIM));

  // R6
  min_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> ($past(off_cnt_q) >= TOFF_LIM));

  // R7
  min_per_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> ($past(per_cnt_q) >= PER_LIM));

  // R10
  end_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> (!$past(ramp_i) && !$past(inhibit_i)));

endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl
  import pfc_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned TON_LO_CYC   = 1250,
  parameter int unsigned TON_HI_CYC   = 400,
  parameter int unsigned BLANK_CYC    = 13,
  parameter int unsigned TOFF_MIN_CYC = 50,
  parameter int unsigned TPER_MIN_CYC = 200,
  parameter int unsigned RESTART_CYC  = 2500,
  parameter int unsigned OVP_DEB_CYC  = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fault_i,
  input  logic zcd_i,
  input  logic cs_over_i,
  input  logic ramp_trip_i,
  input  logic ovp_i,
  input  logic burst_stop_i,
  input  logic burst_start_i,
  input  logic high_line_i,
  output logic gate_o
);

  logic [SYNC_W-1:0] raw, syn;
  logic              run, inhibit;

  always_comb begin
    raw             = '0;
    raw[IDX_ZCD]    = zcd_i;
    raw[IDX_CS]     = cs_over_i;
    raw[IDX_RAMP]   = ramp_trip_i;
    raw[IDX_OVP]    = ovp_i;
    raw[IDX_BSTOP]  = burst_stop_i;
    raw[IDX_BSTART] = burst_start_i;
    raw[IDX_HILINE] = high_line_i;
  end

  assign run = en_i & ~fault_i;

  pfc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  pfc_gate_inhibit #(.OVP_DEB_CYC(OVP_DEB_CYC)) u_inhibit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .ovp_i    (syn[IDX_OVP]),
    .bstop_i  (syn[IDX_BSTOP]),
    .bstart_i (syn[IDX_BSTART]),
    .inhibit_o(inhibit)
  );

  pfc_gate_timer #(
    .TON_LO_CYC  (TON_LO_CYC),
    .TON_HI_CYC  (TON_HI_CYC),
    .BLANK_CYC   (BLANK_CYC),
    .TOFF_MIN_CYC(TOFF_MIN_CYC),
    .TPER_MIN_CYC(TPER_MIN_CYC),
    .RESTART_CYC (RESTART_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .zcd_i      (syn[IDX_ZCD]),
    .cs_i       (syn[IDX_CS]),
    .ramp_i     (syn[IDX_RAMP]),
    .high_line_i(syn[IDX_HILINE]),
    .inhibit_i  (inhibit),
    .gate_o     (gate_o)
  );

endmodule

// File: tb/pfc_gate_ctrl_bench.sv
module pfc_gate_ctrl_bench;

  localparam int TON_LO = 1250, TON_HI = 400, BLANK = 13;
  localparam int TOFF = 50, TPER = 200, RESTART = 2500, OVP_DEB = 2500;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b1, fault = 1'b0, zcd = 1'b0, cs = 1'b0, ramp = 1'b1;
  logic ovp = 1'b0, bstop = 1'b0, bstart = 1'b0, hiline = 1'b0;
  logic gate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  pfc_gate_ctrl u_pfc_gate_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .fault_i      (fault),
    .zcd_i        (zcd),
    .cs_over_i    (cs),
    .ramp_trip_i  (ramp),
    .ovp_i        (ovp),
    .burst_stop_i (bstop),
    .burst_start_i(bstart),
    .high_line_i  (hiline),
    .gate_o       (gate)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input bit lvl, input int len, input string tag);
    exp_t e;
    e.lvl = lvl;
    e.len = len;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wait_q();
    while (expq.size() > 0) @(negedge clk);
  endtask

  task automatic park();
    ramp = 1'b1;
    cyc(2600);
  endtask

  // ramp released; ended by a one-cycle ramp flag k cycles later; zcd raised at zat
  task automatic on_off(input int k, input int zat);
    ramp = 1'b0;
    for (int i = 1; i <= k; i++) begin
      cyc(1);
      if (i == zat) zcd = 1'b1;
    end
    ramp = 1'b1;
    cyc(1);
    ramp = 1'b0;
    if (zat == k + 1) zcd = 1'b1;
  endtask

  task automatic stay_low(input int n, input string tag);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (gate) hi++;
    end
    chk(hi == 0, tag, hi, 0);
  endtask

  // monitor: measures each gate interval and compares with the queue front
  initial begin
    bit cur;
    int len;
    cur = 1'b0;
    len = 0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (gate == cur) begin
        len++;
      end else begin
        if (expq.size() > 0 && expq[0].lvl == cur) begin
          exp_t e;
          e = expq.pop_front();
          chk(len == e.len, e.tag, len, e.len);
        end
        cur = gate;
        len = 1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(5);
    chk(gate == 1'b0, "R1 in reset", gate, 0);
    rst_ni = 1'b1;
    cyc(3);
    chk(gate == 1'b0, "R1 after reset", gate, 0);
    // R10: restart timer saturates while ramp flag held, no turn-on
    stay_low(3000, "R10 ramp held");

    // R2 low-line max on
    park();
    push(1'b1, TON_LO, "R2");
    ramp = 1'b0;
    wait_q();
    ramp = 1'b1;

    // R3 high-line max on
    hiline = 1'b1;
    park();
    push(1'b1, TON_HI, "R3");
    ramp = 1'b0;
    wait_q();
    ramp = 1'b1;
    hiline = 1'b0;

    // R4 ramp end, width equals release-to-trip distance
    park();
    push(1'b1, 100, "R4");
    ramp = 1'b0;
    cyc(100);
    ramp = 1'b1;
    wait_q();

    // R5 current flag held from before turn-on: blanking width
    park();
    cs = 1'b1;
    push(1'b1, BLANK, "R5 blank");
    ramp = 1'b0;
    wait_q();
    ramp = 1'b1;
    cs = 1'b0;

    // R5 current flag after window
    park();
    push(1'b1, 60, "R5 late");
    ramp = 1'b0;
    cyc(60);
    cs = 1'b1;
    wait_q();
    ramp = 1'b1;
    cs = 1'b0;

    // R6 min off time
    park();
    push(1'b1, 300, "R6 high");
    push(1'b0, TOFF, "R6 low");
    on_off(300, 301);
    wait_q();
    ramp = 1'b1;
    zcd = 1'b0;

    // R7 min period
    park();
    push(1'b1, 20, "R7 high");
    push(1'b0, TPER - 20, "R7 low");
    on_off(20, 21);
    wait_q();
    ramp = 1'b1;
    zcd = 1'b0;

    // R8 restart without zcd
    park();
    push(1'b1, 100, "R8 high");
    push(1'b0, RESTART, "R8 low");
    on_off(100, -1);
    wait_q();
    ramp = 1'b1;

    // R9 zcd edge during on-period discarded
    park();
    push(1'b1, 100, "R9 high");
    push(1'b0, RESTART, "R9 low");
    on_off(100, 50);
    wait_q();
    ramp = 1'b1;
    zcd = 1'b0;

    // R11 persistent over-voltage blocks, release resumes
    park();
    ovp = 1'b1;
    cyc(OVP_DEB + 100);
    ramp = 1'b0;
    stay_low(3000, "R11 blocked");
    ovp = 1'b0;
    cyc(6);
    chk(gate == 1'b1, "R11 resume", gate, 1);
    ramp = 1'b1;

    // R11 short over-voltage has no effect
    park();
    ovp = 1'b1;
    cyc(1000);
    ramp = 1'b0;
    cyc(6);
    chk(gate == 1'b1, "R11 short", gate, 1);
    cyc(994);
    ovp = 1'b0;
    ramp = 1'b1;

    // R12 burst stop holds, start releases
    park();
    bstop = 1'b1;
    cyc(5);
    bstop = 1'b0;
    ramp = 1'b0;
    stay_low(3000, "R12 hold");
    bstart = 1'b1;
    cyc(6);
    chk(gate == 1'b1, "R12 release", gate, 1);
    bstart = 1'b0;
    ramp = 1'b1;

    // R13 enable and fault
    park();
    ramp = 1'b0;
    cyc(20);
    chk(gate == 1'b1, "R13 pre", gate, 1);
    en = 1'b0;
    cyc(1);
    chk(gate == 1'b0, "R13 enable off", gate, 0);
    cyc(10);
    en = 1'b1;
    cyc(2400);
    chk(gate == 1'b0, "R13 timers cleared", gate, 0);
    cyc(105);
    chk(gate == 1'b1, "R13 restart after enable", gate, 1);
    fault = 1'b1;
    cyc(1);
    chk(gate == 1'b0, "R13 fault", gate, 0);
    fault = 1'b0;
    ramp = 1'b1;
    cyc(10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule